// File: doc/BRIEF.md
# Cassette FSK Record Writer

This block generates the square-wave recording signal for an audio cassette from a clock-cycle timebase. A start command carries a header length, a first address and a last address. The block then plays a long header tone, an asymmetric sync bit and every byte of the address range onto a single tape line. Each bit is made of two half-cycles, and the line inverts at the end of every half-cycle. A data value is encoded by the length of its half-cycles: short for a zero and long for a one.

Bytes come from a memory read port with one cycle of latency. The read for the next byte is issued during the final half-cycle of the byte in progress, so there is never a gap between bytes. All half-cycle lengths are parameters and every half-cycle has its exact length.

The controller is a five-state machine. `ST_IDLE` moves to `ST_HEAD` on a start command with a nonzero header count, or straight to `ST_SYNC_A` when the count is zero. `ST_HEAD` moves to `ST_SYNC_A` after its last header half-cycle. `ST_SYNC_A` (the short half of the sync bit) moves to `ST_SYNC_B`, and the first memory read is issued on that transition. `ST_SYNC_B` moves to `ST_DATA`. `ST_DATA` loops from byte to byte and returns to `ST_IDLE` after the final half-cycle of the last byte, raising `done` at that point.

Top module: `tape_fsk_writer`

## Requirements
- R1: After reset, `tape_out`, `busy`, `done` and `mem_rd` are all 0.
- R2: A start is accepted only while `busy` is 0, and `busy` is 1 in the cycle after acceptance. A start while busy has no effect on the waveform, the reads or the number of runs.
- R3: The first half-cycle begins in the cycle after the accepting edge. The header is `2*hdr_count*BLK_BITS` half-cycles of `HDR_HALF` clocks each, and a count of 0 omits the header.
- R4: The sync bit is one `SYNC_HALF` half-cycle followed by one `ZERO_HALF` half-cycle.
- R5: A data 0 bit is two `ZERO_HALF` half-cycles, and a data 1 bit is two `ONE_HALF` half-cycles.
- R6: Bytes are sent in increasing address order, starting at `start_addr`, each most significant bit first.
- R7: The run ends after the byte whose address, compared before it is incremented, is greater than or equal to `end_addr` (unsigned). When `start_addr > end_addr`, exactly one byte is sent.
- R8: Each read is a one-cycle `mem_rd` pulse, and `mem_rdata` is taken in the cycle that follows it. The first byte's read happens when the sync bit's second half begins. The read of each following byte happens when the previous byte's final half-cycle begins. One read is issued per byte, at that byte's address.
- R9: `done` is a one-cycle pulse in the cycle after the final tape edge of the last byte, and `busy` is 0 from that cycle on.
- R10: `tape_out` inverts exactly at half-cycle boundaries and is stable at all other times, including while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock is the timing unit |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start command, sampled while idle |
| hdr_count | input | CNT_W | Header length in units of BLK_BITS bits |
| start_addr | input | ADDR_W | Address of the first byte |
| end_addr | input | ADDR_W | Address of the last byte |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_rd` |
| tape_out | output | 1 | Recording waveform |
| busy | output | 1 | A record is in progress |
| done | output | 1 | One-cycle end-of-record pulse |

## Verification
The embedded assertions are checked on every cycle:
- the tape line inverts on every timer expiry and at no other time;
- each read strobe lasts one cycle, and its data is captured before the next boundary consumes it;
- no read is requested past the last address;
- `done` is a single-cycle pulse that only occurs while idle.

Other behaviours can only be shown by the bench's scenarios, because they need the whole record:
- the exact length of every half-cycle;
- the header count, including zero;
- the sync shape;
- MSB-first coding of memory contents;
- the end rule when the first address is above the last;
- the sequence of read addresses;
- ignoring a second start in mid-record.

// File: rtl/tape_wr_pkg.sv
package tape_wr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_SYNC_A,
        ST_SYNC_B,
        ST_DATA
    } wr_state_e;
endpackage

// File: rtl/tape_half_timer.sv
module tape_half_timer #(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    output logic             tick
);
    logic [LEN_W-1:0] cnt_q;

    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load || tick) begin
            cnt_q <= len_in - LEN_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - LEN_W'(1);
        end
    end

    // R10: a boundary cannot follow directly on a load of a length above one
    a_r10_no_early_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (load && len_in > LEN_W'(1)) |=> !tick);
endmodule

// File: rtl/tape_byte_fetch.sv
module tape_byte_fetch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic              req_first,
    input  logic              req_next,
    input  logic              advance,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] nxt_byte,
    output logic              at_last
);
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] end_q;
    logic              rd_d;

    assign at_last = (cur_q >= end_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            end_q    <= '0;
            mem_rd   <= 1'b0;
            mem_addr <= '0;
            rd_d     <= 1'b0;
            nxt_byte <= '0;
        end else begin
            mem_rd <= 1'b0;
            rd_d   <= mem_rd;
            if (arm) begin
                cur_q <= start_addr;
                end_q <= end_addr;
            end
            if (req_first) begin
                mem_rd   <= 1'b1;
                mem_addr <= cur_q;
            end
            if (req_next) begin
                mem_rd   <= 1'b1;
                mem_addr <= cur_q + ADDR_W'(1);
            end
            if (advance) begin
                cur_q <= cur_q + ADDR_W'(1);
            end
            if (rd_d) begin
                nxt_byte <= mem_rdata;
            end
        end
    end

    // R8: read strobes are single-cycle pulses
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    // R7: no read is requested once the last address is in progress
    a_r7_no_read_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        req_next |-> !at_last);
endmodule

// File: rtl/tape_fsk_writer.sv
module tape_fsk_writer
    import tape_wr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 8,
    parameter int BLK_BITS  = 128,
    parameter int HDR_HALF  = 593,
    parameter int SYNC_HALF = 181,
    parameter int ZERO_HALF = 239,
    parameter int ONE_HALF  = 474
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  hdr_count,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              tape_out,
    output logic              busy,
    output logic              done
);
    localparam int MAX_A   = (HDR_HALF > ONE_HALF) ? HDR_HALF : ONE_HALF;
    localparam int MAX_B   = (SYNC_HALF > ZERO_HALF) ? SYNC_HALF : ZERO_HALF;
    localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int HC_W    = CNT_W + $clog2(BLK_BITS) + 2;
    localparam int HALVES  = 2 * DATA_W;
    localparam int IDX_W   = $clog2(HALVES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HALVES - 1);

    wr_state_e         state_q, state_nx;
    logic              tick, accept, load, fin;
    logic              req_first, req_next, advance, at_last;
    logic [LEN_W-1:0]  len_nx;
    logic [HC_W-1:0]   hrem_q;
    logic [IDX_W-1:0]  hidx_q;
    logic [DATA_W-1:0] shreg_q, nxt_byte;

    function automatic logic [LEN_W-1:0] bit_len(input logic b);
        return b ? LEN_W'(ONE_HALF) : LEN_W'(ZERO_HALF);
    endfunction

    assign accept = start && (state_q == ST_IDLE);
    assign load   = accept;
    assign busy   = (state_q != ST_IDLE);

    tape_half_timer #(.LEN_W(LEN_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .load   (load),
        .len_in (len_nx),
        .tick   (tick)
    );

    tape_byte_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fetch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (accept),
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .req_first  (req_first),
        .req_next   (req_next),
        .advance    (advance),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .nxt_byte   (nxt_byte),
        .at_last    (at_last)
    );

    // Next state and control
    always_comb begin
        state_nx  = state_q;
        len_nx    = '0;
        req_first = 1'b0;
        req_next  = 1'b0;
        advance   = 1'b0;
        fin       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (hdr_count != '0) begin
                        state_nx = ST_HEAD;
                        len_nx   = LEN_W'(HDR_HALF);
                    end else begin
                        state_nx = ST_SYNC_A;
                        len_nx   = LEN_W'(SYNC_HALF);
                    end
                end
            end
            ST_HEAD: begin
                if (tick) begin
                    if (hrem_q == '0) begin
                        state_nx = ST_SYNC_A;
                        len_nx   = LEN_W'(SYNC_HALF);
                    end else begin
                        len_nx   = LEN_W'(HDR_HALF);
                    end
                end
            end
            ST_SYNC_A: begin
                if (tick) begin
                    state_nx  = ST_SYNC_B;
                    len_nx    = LEN_W'(ZERO_HALF);
                    req_first = 1'b1;
                end
            end
            ST_SYNC_B: begin
                if (tick) begin
                    state_nx = ST_DATA;
                    len_nx   = bit_len(nxt_byte[DATA_W-1]);
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (hidx_q == IDX_LAST) begin
                        if (at_last) begin
                            state_nx = ST_IDLE;
                            fin      = 1'b1;
                        end else begin
                            advance = 1'b1;
                            len_nx  = bit_len(nxt_byte[DATA_W-1]);
                        end
                    end else if (hidx_q[0]) begin
                        len_nx = bit_len(shreg_q[DATA_W-2]);
                    end else begin
                        len_nx = bit_len(shreg_q[DATA_W-1]);
                        if ((hidx_q == IDX_LAST - IDX_W'(1)) && !at_last) begin
                            req_next = 1'b1;
                        end
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tape_out <= 1'b0;
            done     <= 1'b0;
            hrem_q   <= '0;
            hidx_q   <= '0;
            shreg_q  <= '0;
        end else begin
            done <= fin;
            if (tick) tape_out <= ~tape_out;
            if (accept) begin
                hrem_q <= HC_W'(hdr_count) * HC_W'(2 * BLK_BITS) - HC_W'(1);
            end
            if (state_q == ST_HEAD && tick && hrem_q != '0) begin
                hrem_q <= hrem_q - HC_W'(1);
            end
            if (state_q == ST_SYNC_B && tick) begin
                shreg_q <= nxt_byte;
                hidx_q  <= '0;
            end
            if (state_q == ST_DATA && tick) begin
                if (hidx_q == IDX_LAST) begin
                    shreg_q <= nxt_byte;
                    hidx_q  <= '0;
                end else begin
                    if (hidx_q[0]) shreg_q <= shreg_q << 1;
                    hidx_q <= hidx_q + IDX_W'(1);
                end
            end
        end
    end

    // R10: line inverts on each boundary and holds otherwise
    a_r10_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (tape_out != $past(tape_out)));
    a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tape_out));
    // R8: fetched byte is captured before the boundary that uses it
    a_r8_fetch_before_use: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !tick);
    // R9: done is a single pulse seen only when idle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2: a start during a record cannot end it early
    a_r2_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !tick) |=> busy);
endmodule

// File: tb/tape_fsk_writer_tb_top.sv
module tape_fsk_writer_tb_top;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int CW = 3;
    localparam int BLK = 2;
    localparam int HDR = 10;
    localparam int SYN = 4;
    localparam int ZER = 5;
    localparam int ONE = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CW-1:0] hdr_count = '0;
    logic [AW-1:0] start_addr = '0, end_addr = '0;
    logic mem_rd;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic tape_out, busy, done;

    tape_fsk_writer #(
        .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .BLK_BITS(BLK),
        .HDR_HALF(HDR), .SYNC_HALF(SYN), .ZERO_HALF(ZER), .ONE_HALF(ONE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .hdr_count(hdr_count),
        .start_addr(start_addr), .end_addr(end_addr), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .tape_out(tape_out),
        .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] memf(input logic [7:0] a);
        return (a * 8'd29 + 8'h5A) ^ (a >> 3);
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

    int cyc = 0;
    always @(posedge clk) cyc++;

    int n_chk = 0, n_bad = 0;
    int exp_len[$];
    int exp_tag[$];
    logic [7:0] exp_addr[$];
    int bad_tag[0:9];
    int extra, done_cnt, done_t, addr_bad, last_t, ln, tg;
    bit mon_on = 0;
    logic prev_tape = 1'b0;

    task automatic chk(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (tape_out !== prev_tape) begin
                if (exp_len.size() == 0) extra++;
                else begin
                    ln = exp_len.pop_front();
                    tg = exp_tag.pop_front();
                    if (cyc - last_t != ln) bad_tag[tg]++;
                    last_t = cyc;
                end
            end
            if (done === 1'b1) begin
                done_cnt++;
                done_t = cyc;
            end
            if (mem_rd === 1'b1) begin
                if (exp_addr.size() == 0) addr_bad++;
                else if (mem_addr !== exp_addr.pop_front()) addr_bad++;
            end
        end
        prev_tape = tape_out;
    end

    task automatic run(input int hc, input int sa, input int ea, input bit poke);
        int a, n;
        logic [7:0] b;
        exp_len.delete(); exp_tag.delete(); exp_addr.delete();
        for (int i = 0; i < 10; i++) bad_tag[i] = 0;
        extra = 0; done_cnt = 0; done_t = -1; addr_bad = 0;
        for (int i = 0; i < 2 * hc * BLK; i++) begin
            exp_len.push_back(HDR); exp_tag.push_back(3);
        end
        exp_len.push_back(SYN); exp_tag.push_back(4);
        exp_len.push_back(ZER); exp_tag.push_back(4);
        a = sa;
        forever begin
            exp_addr.push_back(8'(a));
            b = memf(8'(a));
            for (int k = 7; k >= 0; k--) begin
                for (int h = 0; h < 2; h++) begin
                    exp_len.push_back(b[k] ? ONE : ZER); exp_tag.push_back(6);
                end
            end
            if (a >= ea) break;
            a++;
        end
        @(negedge clk);
        start = 1'b1; hdr_count = CW'(hc); start_addr = AW'(sa); end_addr = AW'(ea);
        last_t = cyc + 1;
        mon_on = 1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after accepted start", int'(busy), 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1; hdr_count = 3'd7; start_addr = 8'h00; end_addr = 8'hFF;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (done_cnt == 0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (30) @(negedge clk);
        chk("R3 header half-cycles", bad_tag[3], 0);
        chk("R4 sync half-cycles", bad_tag[4], 0);
        chk("R5 R6 data half-cycles", bad_tag[6], 0);
        chk("R7 missing half-cycles", exp_len.size(), 0);
        chk("R10 extra tape edges", extra, 0);
        chk("R8 read address errors", addr_bad + exp_addr.size(), 0);
        chk("R9 done pulse count", done_cnt, 1);
        chk("R9 done after final edge", done_t, last_t);
        chk("R9 busy low after done", int'(busy), 0);
        if (poke) chk("R2 start while busy ignored", extra + int'(busy), 0);
        mon_on = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int hc, sa, ln2;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset tape_out", int'(tape_out), 0);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset mem_rd", int'(mem_rd), 0);
        run(1, 10, 12, 0);
        run(0, 5, 5, 0);      // R3: zero header count
        run(2, 40, 38, 0);    // R7: start above end gives one byte
        run(1, 254, 255, 1);  // R7 top address, R2 poke
        for (int i = 0; i < 12; i++) begin
            hc  = $urandom_range(0, 3);
            sa  = $urandom_range(0, 250);
            ln2 = $urandom_range(0, 5);
            run(hc, sa, sa + ln2, (i % 4) == 1);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule